// File: doc/BRIEF.md
# Host mailbox FIFO register interface

This block sits between a host processor's memory-mapped bus and a small system-management microcontroller. The host sends command bytes by writing a data register, which loads a byte-wide transmit FIFO. The microcontroller takes those bytes from a valid/ready stream. Reply bytes come back from the microcontroller on a second valid/ready stream into a byte-wide receive FIFO, and the host reads them through the same data register. A status register reports the fill state of both FIFOs and a sticky receive-overflow flag. An interrupt register combines a per-condition enable mask with a live view of the enabled, pending conditions. A single registered interrupt line tells the host when any enabled condition is present.

The bus side uses a one-cycle access. Read data is combinational during the access, and any read or write side effects take place at the clock edge that ends it. The window is 32 bytes, decoded on word boundaries.

Top module: `hostlink_mbox`

## Requirements
- R1: Byte offset 0 selects the interrupt register, offset 4 the data register and offset 8 the status register. Every other word in the 32-byte window reads as zero, and writes to those words have no effect.
- R2: After reset the status register reads 0x3, the interrupt register reads 0x0, irq is low and tx_out_valid is low.
- R3: A write to the data register pushes bits 15:8 of the written word into the transmit FIFO and ignores all other bits. The bytes are presented on tx_out_data in write order. A byte is held stable while tx_out_valid is high and tx_out_ready is low.
- R4: A data-register write while the transmit FIFO is full, with no byte leaving in that cycle, is discarded and leaves the FIFO contents unchanged.
- R5: A read of the data register returns the oldest received byte in bits 15:8, with all other bits zero, and removes that byte from the receive FIFO.
- R6: A read of the data register while the receive FIFO is empty returns zero and removes nothing.
- R7: The status bits are: bit 0 transmit FIFO empty, bit 1 transmit FIFO not full, bit 2 receive FIFO not empty, bit 3 receive overflow. Bits 0 to 2 follow FIFO occupancy, and writes to them have no effect.
- R8: A byte offered on rx_in while the receive FIFO is full, with no host pop in that cycle, is dropped and sets the overflow flag. rx_in_ready is low while the receive FIFO is full.
- R9: The overflow flag stays set until a status write with bit 3 set. Writing back the value just read clears it. A new overflow in the same cycle as the clearing write leaves the flag set.
- R10: Interrupt register bits 7:4 are enable masks for the four conditions, in the same bit order as the status bits, and they read back as written. Bits 3:0 read as status AND mask, and writes to bits 3:0 have no effect.
- R11: irq is active high and registered. It equals the OR of (status bit AND mask bit) from the previous cycle, so with mask 0x4 alone it goes high whenever a reply byte is waiting.
- R12: When the receive FIFO is full and a host data read and a microcontroller push fall in the same cycle, the read returns the oldest byte, the pushed byte is stored, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| tx_out_valid | output | 1 | Command byte available for the microcontroller |
| tx_out_ready | input | 1 | Microcontroller takes the byte |
| tx_out_data | output | 8 | Command byte |
| rx_in_valid | input | 1 | Microcontroller offers a reply byte |
| rx_in_ready | output | 1 | Receive FIFO has room |
| rx_in_data | input | 8 | Reply byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a host pop of the receive FIFO and a microcontroller push into it. The second pair is a new overflow and a write-one-to-clear of the overflow flag. The bench provokes each pair by driving the bus access and rx_in_valid in the same cycle with the receive FIFO full. It then judges the result from the status register (overflow bit 3) and from the order and content of the bytes read back afterwards: the pushed byte must be retained after a pop, and the flag must stay set after a clearing write that coincides with an overflow.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Data byte lane inside the 32-bit data word
  localparam int unsigned BYTE_LSB = 8;
  // Word indices inside the register window
  localparam int unsigned IDX_INTR = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_STAT = 2;
  // Condition bit positions, shared by status, request and mask fields
  localparam int unsigned C_TXE  = 0;
  localparam int unsigned C_TXNF = 1;
  localparam int unsigned C_RXNE = 2;
  localparam int unsigned C_RXO  = 3;
  localparam int unsigned NCOND  = 4;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL_CNT);
  assign dout  = mem_q[rd_q];

  always_comb begin
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);
    wr_d    = do_push ? wr_q + 1'b1 : wr_q;
    rd_d    = do_pop  ? rd_q + 1'b1 : rd_q;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic irq_d;

  for (genvar i = 0; i < N; i++) begin : g_pend
    assign pend[i] = cond[i] & mask[i];
  end

  assign irq_d = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned TX_AW  = 2,
  parameter int unsigned RX_AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [7:0]        tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [7:0]        rx_in_data,
  output logic              irq
);
  localparam int unsigned IDXW = ADDR_W - 2;

  logic [IDXW-1:0]  idx;
  logic             hit_intr, hit_data, hit_stat;
  logic             tx_push, tx_empty, tx_full;
  logic             rx_pop, rx_empty, rx_full, rx_pop_eff, rx_drop;
  logic [7:0]       rx_dout;
  logic [NCOND-1:0] mask_q, mask_d, cond_vec, pend;
  logic             ovf_q, ovf_d, ovf_clr;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign hit_intr = bus_sel && (idx == IDXW'(IDX_INTR));
  assign hit_data = bus_sel && (idx == IDXW'(IDX_DATA));
  assign hit_stat = bus_sel && (idx == IDXW'(IDX_STAT));

  assign tx_push    = hit_data && bus_we;
  assign rx_pop     = hit_data && !bus_we;
  assign rx_pop_eff = rx_pop && !rx_empty;
  assign rx_drop    = rx_in_valid && rx_full && !rx_pop_eff;
  assign ovf_clr    = hit_stat && bus_we && bus_wdata[C_RXO];

  mbox_fifo #(.W(8), .AW(TX_AW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(bus_wdata[BYTE_LSB +: 8]),
    .pop(tx_out_ready), .dout(tx_out_data),
    .empty(tx_empty), .full(tx_full)
  );

  mbox_fifo #(.W(8), .AW(RX_AW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_in_valid), .din(rx_in_data),
    .pop(rx_pop), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full)
  );

  assign tx_out_valid = !tx_empty;
  assign rx_in_ready  = !rx_full;

  always_comb begin
    cond_vec         = '0;
    cond_vec[C_TXE]  = tx_empty;
    cond_vec[C_TXNF] = !tx_full;
    cond_vec[C_RXNE] = !rx_empty;
    cond_vec[C_RXO]  = ovf_q;
  end

  always_comb begin
    mask_d = (hit_intr && bus_we) ? bus_wdata[2*NCOND-1:NCOND] : mask_q;
    if (rx_drop)      ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ovf_q  <= ovf_d;
    end
  end

  mbox_irq #(.N(NCOND)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .cond(cond_vec), .mask(mask_q),
    .pend(pend), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (hit_intr)                  bus_rdata[2*NCOND-1:0]     = {mask_q, pend};
      else if (hit_data && !rx_empty) bus_rdata[BYTE_LSB +: 8] = rx_dout;
      else if (hit_stat)             bus_rdata[NCOND-1:0]       = cond_vec;
    end
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [7:0]        tx_out_data,
  input logic              rx_in_valid,
  input logic              rx_in_ready,
  input logic              irq,
  input logic              ovf,
  input logic              rx_empty,
  input logic [3:0]        cond,
  input logic [3:0]        mask
);
  localparam int unsigned IDXW = ADDR_W - 2;
  logic [IDXW-1:0] idx;
  logic data_rd, stat_clr;
  assign idx      = bus_addr[ADDR_W-1:2];
  assign data_rd  = bus_sel && !bus_we && (idx == IDXW'(1));
  assign stat_clr = bus_sel && bus_we && (idx == IDXW'(2)) && bus_wdata[3];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data)); // R3
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && rx_empty |-> bus_rdata == 32'd0); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && !rx_in_ready && !(data_rd && !rx_empty) |=> ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !stat_clr |=> ovf); // R9
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq == $past(|(cond & mask))); // R11
endmodule

bind hostlink_mbox mbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .rx_in_valid(rx_in_valid),
  .rx_in_ready(rx_in_ready), .irq(irq), .ovf(ovf_q),
  .rx_empty(rx_empty), .cond(cond_vec), .mask(mask_q)
);

// File: tb/tb_hostlink_mbox.sv
`timescale 1ns/1ps
module tb_hostlink_mbox;
  localparam int DEPTH = 4;
  localparam logic [4:0] A_INTR = 5'd0, A_DATA = 5'd4, A_STAT = 5'd8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_out_valid, tx_out_ready;
  logic [7:0]  tx_out_data;
  logic        rx_in_valid, rx_in_ready;
  logic [7:0]  rx_in_data;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hostlink_mbox dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    cyc();
    bus_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_in_valid = 1'b1; rx_in_data = b;
    cyc();
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [7:0] b);
    v = tx_out_valid; b = tx_out_data;
    tx_out_ready = 1'b1;
    cyc();
    tx_out_ready = 1'b0;
  endtask

  task automatic mask_sweep(input logic [3:0] cond, input string tag);
    logic [31:0] r;
    logic [3:0]  prev;
    wr(A_INTR, 32'h0); cyc();
    prev = 4'h0;
    for (int m = 0; m < 16; m++) begin
      wr(A_INTR, {24'd0, 4'(m), 4'hF});
      chk({"R11 irq lags one cycle ", tag}, {31'd0, irq}, {31'd0, |(cond & prev)});
      cyc();
      chk({"R11 irq ", tag}, {31'd0, irq}, {31'd0, |(cond & 4'(m))});
      rd(A_INTR, r);
      chk({"R10 intr readback ", tag}, r, {24'd0, 4'(m), cond & 4'(m)});
      prev = 4'(m);
    end
    wr(A_INTR, 32'h0); cyc();
  endtask

  task automatic drain_rx();
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) rd(A_DATA, r);
  endtask

  task automatic drain_tx();
    logic v; logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) tx_take(v, b);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [7:0]  b;
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    tx_out_ready = 0; rx_in_valid = 0; rx_in_data = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R2 reset state
    rd(A_STAT, r); chk("R2 status", r, 32'h3);
    rd(A_INTR, r); chk("R2 intr", r, 32'h0);
    chk("R2 irq", {31'd0, irq}, 32'd0);
    chk("R2 tx_out_valid", {31'd0, tx_out_valid}, 32'd0);

    // R1 reserved words
    for (int w = 3; w < 8; w++) begin
      wr(5'(w * 4), 32'hFFFF_FFFF);
      rd(5'(w * 4), r); chk("R1 reserved read", r, 32'h0);
    end
    rd(A_STAT, r); chk("R1 status after reserved writes", r, 32'h3);
    rd(A_INTR, r); chk("R1 intr after reserved writes", r, 32'h0);

    // R3 / R4 transmit path
    for (int i = 0; i <= DEPTH; i++) wr(A_DATA, {8'hA5, 8'h5A, 8'(8'h10 + i), 8'hC3});
    rd(A_STAT, r); chk("R7 status tx full", r, 32'h0);
    for (int i = 0; i <= DEPTH; i++) begin
      tx_take(v, b);
      if (i < DEPTH) begin
        chk("R3 tx valid", {31'd0, v}, 32'd1);
        chk("R3 tx byte order", {24'd0, b}, {24'd0, 8'(8'h10 + i)});
      end else begin
        chk("R4 extra byte discarded", {31'd0, v}, 32'd0);
      end
    end
    rd(A_STAT, r); chk("R7 status tx drained", r, 32'h3);

    // R5 / R6 / R7 receive path
    for (int i = 0; i < 3; i++) begin
      chk("R8 ready when not full", {31'd0, rx_in_ready}, 32'd1);
      rx_push(8'(8'h80 + 8'(i * 7)));
    end
    rd(A_STAT, r); chk("R7 status rx waiting", r, 32'h7);
    for (int i = 0; i < 3; i++) begin
      rd(A_DATA, r); chk("R5 rx byte", r, {16'd0, 8'(8'h80 + 8'(i * 7)), 8'd0});
    end
    rd(A_DATA, r); chk("R6 empty read zero", r, 32'h0);
    rd(A_STAT, r); chk("R6 status after empty read", r, 32'h3);

    // R8 overflow
    for (int i = 0; i < DEPTH; i++) rx_push(8'(8'h20 + i));
    chk("R8 ready low when full", {31'd0, rx_in_ready}, 32'd0);
    rx_push(8'hEE);
    rd(A_STAT, r); chk("R8 overflow flagged", r, 32'hF);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, r); chk("R8 bytes kept", r, {16'd0, 8'(8'h20 + i), 8'd0});
    end
    rd(A_DATA, r); chk("R8 dropped byte absent", r, 32'h0);
    rd(A_STAT, r); chk("R9 overflow sticky", r, 32'hB);

    // R7 live bits ignore writes, R9 write-back clears
    wr(A_STAT, 32'h7);
    rd(A_STAT, r); chk("R7 live bits write ignored", r, 32'hB);
    wr(A_STAT, r);
    rd(A_STAT, r); chk("R9 write-back clears", r, 32'h3);

    // R9 clear and new overflow in the same cycle
    for (int i = 0; i < DEPTH; i++) rx_push(8'(8'h40 + i));
    bus_sel = 1; bus_we = 1; bus_addr = A_STAT; bus_wdata = 32'h8;
    rx_in_valid = 1; rx_in_data = 8'h4F;
    cyc();
    bus_sel = 0; bus_we = 0; rx_in_valid = 0;
    rd(A_STAT, r); chk("R9 set beats clear", r, 32'hF);
    drain_rx(); wr(A_STAT, 32'h8);
    rd(A_STAT, r); chk("R9 cleared after drain", r, 32'h3);

    // R12 pop and push on a full receive FIFO
    for (int i = 0; i < DEPTH; i++) rx_push(8'(8'h30 + i));
    bus_sel = 1; bus_we = 0; bus_addr = A_DATA;
    rx_in_valid = 1; rx_in_data = 8'h3F;
    #1 r = bus_rdata;
    chk("R12 oldest byte returned", r, 32'h3000);
    cyc();
    bus_sel = 0; rx_in_valid = 0;
    rd(A_STAT, r); chk("R12 no overflow", r, 32'h7);
    for (int i = 1; i <= DEPTH; i++) begin
      rd(A_DATA, r);
      chk("R12 order kept", r, {16'd0, (i == DEPTH) ? 8'h3F : 8'(8'h30 + i), 8'd0});
    end

    // R10 / R11 mask sweeps over four condition patterns
    mask_sweep(4'h3, "idle");
    rx_push(8'h55);
    mask_sweep(4'h7, "rx waiting");
    for (int i = 0; i < DEPTH; i++) wr(A_DATA, 32'h0000_6600);
    mask_sweep(4'h4, "tx full rx waiting");
    for (int i = 1; i < DEPTH; i++) rx_push(8'h66);
    rx_push(8'h77);
    mask_sweep(4'hC, "both full overflow");
    drain_rx(); drain_tx(); wr(A_STAT, 32'hF);
    rd(A_STAT, r); chk("R9 final clear", r, 32'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule